// File: doc/BRIEF.md
# Single-Bus Accumulator Machine Datapath

This block is the register datapath of a small 16-bit accumulator machine. It holds a program counter and a memory address register (12 bits each), a memory buffer, an accumulator and an instruction register (16 bits each), an output latch, and a word memory. All of them meet on one shared 16-bit bus. Each cycle a 3-bit source code chooses which element drives the bus and a 3-bit destination code chooses which element loads from it on the next rising clock edge.

An external control sequencer steps the datapath through fetch, decode and execute by issuing one source/destination pair per cycle. It also raises strobes for memory read, memory write and program-counter increment. The memory is always addressed through the address register. It can be preloaded over a separate initialisation port before the machine runs. The instruction register exposes its opcode and address fields directly to the sequencer.

Top module: `acc_bus_datapath`

## Requirements
- R1: While `rst_n` is low and after its release, PC, MAR, MBR, AC, IR and OUT all read zero until a bus load or increment changes them.
- R2: Source code `src_sel` selects the bus driver as follows: 000 memory, 001 MAR, 010 PC, 011 MBR, 100 AC, 101 `ext_in`, 110 OUT, 111 IR. A 12-bit register drives the bus zero-extended in bits 15:12.
- R3: Destination code `dst_sel` uses the same numbering: 001 MAR, 010 PC, 011 MBR, 100 AC, 110 OUT, 111 IR. Only the selected register loads, on the rising edge. MAR and PC take bus bits 11:0. Codes 000 and 101 load no register, and every other register holds its value.
- R4: With source 000 and `mem_rd` high, the bus carries the memory word at the address held in MAR. With source 000 and `mem_rd` low, the bus is zero.
- R5: When `mem_wr` is high at a rising edge, the current bus word is stored at the address held in MAR, and no other address changes.
- R6: When `pc_inc` is high and PC is not the destination, PC becomes PC+1 modulo 4096, so 4095 wraps to 0. When PC is also the bus destination, the bus load takes priority.
- R7: `ir_opcode` equals IR bits 15:12 and `ir_addr` equals IR bits 11:0.
- R8: When `init_we` is high at a rising edge, `init_data` is written at `init_addr`. This takes priority over a `mem_wr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the registers |
| src_sel | input | 3 | Bus source code |
| dst_sel | input | 3 | Bus destination code |
| mem_rd | input | 1 | Memory read strobe (enables memory onto bus) |
| mem_wr | input | 1 | Memory write strobe (bus to memory at MAR) |
| pc_inc | input | 1 | Program counter increment strobe |
| ext_in | input | 16 | External input word (source code 101) |
| init_we | input | 1 | Memory preload write enable |
| init_addr | input | 12 | Memory preload address |
| init_data | input | 16 | Memory preload data |
| bus | output | 16 | Current shared bus value |
| pc_q | output | 12 | Program counter |
| mar_q | output | 12 | Memory address register |
| mbr_q | output | 16 | Memory buffer register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| out_q | output | 16 | Output latch |
| ir_opcode | output | 4 | IR bits 15:12 |
| ir_addr | output | 12 | IR bits 11:0 |

## Verification
The bench builds the block with its default parameters: a 16-bit word, 12-bit addresses and a full 4096-word memory. This puts the program-counter wrap from 4095 to 0 and the top and bottom memory words within reach of a short run. All 4096 words are preloaded through the initialisation port. A directed indirect-store sequence then drives the codes exactly as a sequencer would. After that, thousands of random source/destination/strobe combinations are compared against a bench-side model of every register and every memory word.

// File: rtl/acc_bus_datapath.sv
module acc_bus_datapath #(
  parameter int DW  = 16,
  parameter int AW  = 12,
  parameter int OPW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    src_sel,
  input  logic [2:0]    dst_sel,
  input  logic          mem_rd,
  input  logic          mem_wr,
  input  logic          pc_inc,
  input  logic [DW-1:0] ext_in,
  input  logic          init_we,
  input  logic [AW-1:0] init_addr,
  input  logic [DW-1:0] init_data,
  output logic [DW-1:0] bus,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] mar_q,
  output logic [DW-1:0] mbr_q,
  output logic [DW-1:0] ac_q,
  output logic [DW-1:0] ir_q,
  output logic [DW-1:0] out_q,
  output logic [OPW-1:0] ir_opcode,
  output logic [AW-1:0] ir_addr
);
  localparam int DEPTH = 1 << AW;
  localparam int PADW  = DW - AW;

  localparam logic [2:0] C_MEM = 3'd0, C_MAR = 3'd1, C_PC  = 3'd2, C_MBR = 3'd3,
                         C_AC  = 3'd4, C_IN  = 3'd5, C_OUT = 3'd6, C_IR  = 3'd7;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_q;

  assign mem_q     = mem[mar_q];
  assign ir_opcode = ir_q[DW-1 -: OPW];
  assign ir_addr   = ir_q[AW-1:0];

  always_comb begin
    case (src_sel)
      C_MEM:   bus = mem_rd ? mem_q : '0;
      C_MAR:   bus = {{PADW{1'b0}}, mar_q};
      C_PC:    bus = {{PADW{1'b0}}, pc_q};
      C_MBR:   bus = mbr_q;
      C_AC:    bus = ac_q;
      C_IN:    bus = ext_in;
      C_OUT:   bus = out_q;
      default: bus = ir_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (init_we)     mem[init_addr] <= init_data;
    else if (mem_wr) mem[mar_q]     <= bus;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ac_q  <= '0;
      ir_q  <= '0;
      out_q <= '0;
    end else begin
      if (dst_sel == C_PC)      pc_q <= bus[AW-1:0];
      else if (pc_inc)          pc_q <= pc_q + 1'b1;
      if (dst_sel == C_MAR) mar_q <= bus[AW-1:0];
      if (dst_sel == C_MBR) mbr_q <= bus;
      if (dst_sel == C_AC)  ac_q  <= bus;
      if (dst_sel == C_IR)  ir_q  <= bus;
      if (dst_sel == C_OUT) out_q <= bus;
    end
  end

  // R6
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && dst_sel != C_PC) |=> pc_q == $past(pc_q) + 1'b1);

  // R6
  pc_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_sel == C_PC) |=> pc_q == $past(bus[AW-1:0]));

  // R3
  mar_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_sel == C_MAR) |=> mar_q == $past(bus[AW-1:0]));

  // R3
  ac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_sel != C_AC) |=> $stable(ac_q));

  // R3
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_sel != C_IR) |=> $stable(ir_q));

  // R4
  mem_write_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !init_we && dst_sel != C_MAR) |=>
      (src_sel != C_MEM || !mem_rd || bus == $past(bus)));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (pc_q == '0 && ac_q == '0 && out_q == '0));
endmodule

// File: tb/tb_acc_bus_datapath.sv
module tb_acc_bus_datapath;
  localparam int DW = 16, AW = 12, DEPTH = 4096;

  logic clk = 0, rst_n = 0;
  logic [2:0] src_sel = 3'd5, dst_sel = 3'd5;
  logic mem_rd = 0, mem_wr = 0, pc_inc = 0, init_we = 0;
  logic [DW-1:0] ext_in = '0, init_data = '0;
  logic [AW-1:0] init_addr = '0;
  logic [DW-1:0] bus, mbr_q, ac_q, ir_q, out_q;
  logic [AW-1:0] pc_q, mar_q, ir_addr;
  logic [3:0] ir_opcode;

  acc_bus_datapath dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .dst_sel(dst_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .pc_inc(pc_inc), .ext_in(ext_in),
    .init_we(init_we), .init_addr(init_addr), .init_data(init_data),
    .bus(bus), .pc_q(pc_q), .mar_q(mar_q), .mbr_q(mbr_q), .ac_q(ac_q),
    .ir_q(ir_q), .out_q(out_q), .ir_opcode(ir_opcode), .ir_addr(ir_addr));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] m_pc, m_mar;
  logic [DW-1:0] m_mbr, m_ac, m_ir, m_out;
  logic [DW-1:0] mm [DEPTH];

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 40503) ^ (a << 3) ^ 16'h5A3C);
  endfunction

  function automatic logic [DW-1:0] exp_bus(input logic [2:0] s, input logic rd, input logic [DW-1:0] xin);
    case (s)
      3'd0: return rd ? mm[m_mar] : '0;
      3'd1: return {4'h0, m_mar};
      3'd2: return {4'h0, m_pc};
      3'd3: return m_mbr;
      3'd4: return m_ac;
      3'd5: return xin;
      3'd6: return m_out;
      default: return m_ir;
    endcase
  endfunction

  task automatic cmp_regs(input string tag);
    chk({tag, " R3 pc"},  {4'h0, pc_q},  {4'h0, m_pc});
    chk({tag, " R3 mar"}, {4'h0, mar_q}, {4'h0, m_mar});
    chk({tag, " R3 mbr"}, mbr_q, m_mbr);
    chk({tag, " R3 ac"},  ac_q,  m_ac);
    chk({tag, " R3 ir"},  ir_q,  m_ir);
    chk({tag, " R3 out"}, out_q, m_out);
    chk({tag, " R7 opcode"}, {12'h0, ir_opcode}, {12'h0, m_ir[15:12]});
    chk({tag, " R7 addr"},   {4'h0, ir_addr},    {4'h0, m_ir[11:0]});
  endtask

  task automatic step(input string tag, input logic [2:0] s, input logic [2:0] d,
                      input logic rd, input logic wr, input logic inc, input logic [DW-1:0] xin);
    logic [DW-1:0] eb;
    @(negedge clk);
    src_sel = s; dst_sel = d; mem_rd = rd; mem_wr = wr; pc_inc = inc; ext_in = xin;
    #1;
    eb = exp_bus(s, rd, xin);
    chk({tag, (s == 3'd0) ? " R4 bus" : " R2 bus"}, bus, eb);
    @(posedge clk);
    if (wr) mm[m_mar] = eb;
    if (d == 3'd2) m_pc = eb[11:0];
    else if (inc) m_pc = m_pc + 1'b1;
    if (d == 3'd1) m_mar = eb[11:0];
    if (d == 3'd3) m_mbr = eb;
    if (d == 3'd4) m_ac = eb;
    if (d == 3'd6) m_out = eb;
    if (d == 3'd7) m_ir = eb;
    #1;
    cmp_regs(tag);
  endtask

  task automatic peek_mem(input string tag, input logic [AW-1:0] a);
    step({tag, " R5 setmar"}, 3'd5, 3'd1, 0, 0, 0, {4'h0, a});
    step({tag, " R5 read"}, 3'd0, 3'd5, 1, 0, 0, '0);
  endtask

  initial begin
    #(10 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357));
    m_pc = '0; m_mar = '0; m_mbr = '0; m_ac = '0; m_ir = '0; m_out = '0;
    rst_n = 0;
    src_sel = 3'd5; dst_sel = 3'd4; ext_in = 16'hBEEF; pc_inc = 1;
    repeat (3) @(posedge clk);
    #1;
    cmp_regs("R1 in reset");
    @(negedge clk);
    rst_n = 1; dst_sel = 3'd5; pc_inc = 0;
    #1;
    cmp_regs("R1 after release");

    // R8 preload all memory
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      init_we = 1; init_addr = AW'(a); init_data = pat(a); mm[a] = pat(a);
    end
    @(negedge clk);
    init_we = 0;
    peek_mem("R8 low", 12'h000);
    peek_mem("R8 top", 12'hFFF);
    peek_mem("R8 mid", 12'h7A5);

    // R8 init beats mem_wr at same address
    step("R8 mar", 3'd5, 3'd1, 0, 0, 0, 16'h0123);
    @(negedge clk);
    init_we = 1; init_addr = 12'h123; init_data = 16'hC0DE;
    src_sel = 3'd5; ext_in = 16'h1111; mem_wr = 1; dst_sel = 3'd5;
    @(posedge clk); #1;
    init_we = 0; mem_wr = 0; mm[12'h123] = 16'hC0DE;
    peek_mem("R8 prio", 12'h123);

    // R4 read strobe low gives zero
    step("R4 rd low", 3'd0, 3'd4, 0, 0, 0, '0);

    // R2 zero extension of 12-bit sources
    step("R2 pc load", 3'd5, 3'd2, 0, 0, 0, 16'hFABC);
    step("R2 pc src", 3'd2, 3'd4, 0, 0, 0, '0);
    step("R2 mar src", 3'd1, 3'd3, 0, 0, 0, '0);

    // R6 wrap and priority
    step("R6 set", 3'd5, 3'd2, 0, 0, 0, 16'h0FFE);
    step("R6 inc", 3'd5, 3'd5, 0, 0, 1, '0);
    step("R6 wrap", 3'd5, 3'd0, 0, 0, 1, '0);
    chk("R6 wrapped pc", {4'h0, pc_q}, 16'h0000);
    step("R6 load wins", 3'd5, 3'd2, 0, 0, 1, 16'h0777);
    chk("R6 priority pc", {4'h0, pc_q}, 16'h0777);

    // indirect store sequence: word at 0x040 = 0x3200 (op 3, addr 0x200); mem[0x200]=0x0300
    @(negedge clk); init_we = 1; init_addr = 12'h040; init_data = 16'h3200; mm[12'h040] = 16'h3200;
    @(negedge clk); init_addr = 12'h200; init_data = 16'h0300; mm[12'h200] = 16'h0300;
    @(negedge clk); init_we = 0;
    step("R3 ac prime", 3'd5, 3'd4, 0, 0, 0, 16'hA5A5);
    step("R3 pc prime", 3'd5, 3'd2, 0, 0, 0, 16'h0040);
    step("R3 mar<-pc", 3'd2, 3'd1, 0, 0, 0, '0);
    step("R4 ir<-m", 3'd0, 3'd7, 1, 0, 0, '0);
    chk("R7 opcode seq", {12'h0, ir_opcode}, 16'h0003);
    step("R6 pc+1", 3'd5, 3'd5, 0, 0, 1, '0);
    step("R7 mar<-ir", 3'd7, 3'd1, 0, 0, 0, '0);
    chk("R7 mar addr", {4'h0, mar_q}, 16'h0200);
    step("R4 mbr<-m", 3'd0, 3'd3, 1, 0, 0, '0);
    step("R3 mar<-mbr", 3'd3, 3'd1, 0, 0, 0, '0);
    step("R3 mbr<-ac", 3'd4, 3'd3, 0, 0, 0, '0);
    step("R5 m<-mbr", 3'd3, 3'd0, 0, 1, 0, '0);
    peek_mem("R5 stored", 12'h300);
    peek_mem("R5 neighbour", 12'h301);
    step("R3 out latch", 3'd4, 3'd6, 0, 0, 0, '0);
    step("R2 out src", 3'd6, 3'd3, 0, 0, 0, '0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] s, d;
      logic rd, wr, inc;
      s = 3'($urandom); d = 3'($urandom);
      rd = ($urandom % 4) != 0; wr = ($urandom % 5) == 0; inc = ($urandom % 3) == 0;
      step("R3 rand", s, d, rd, wr, inc, 16'($urandom));
    end
    for (int a = 0; a < 64; a++) peek_mem("R5 sweep", 12'($urandom));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule